// File: doc/BRIEF.md
# Four-Way Write-Through Data Cache with Victim/Next-Victim Replacement

This block is a write-through data cache for a byte-addressed 24-bit address space. It holds 8 KB as 256 sets of four 8-byte lines. A processor issues one request at a time: a 32-bit word read, or a store of up to four bytes under byte enables. The cache answers read hits from its own storage. On a read miss it fetches the whole 8-byte line from memory, installs it, and returns the requested word. Every store is sent on to memory. A store that hits also updates the cached line. A store that misses leaves the cache unchanged.

Replacement does not keep a full LRU order. Each set keeps two marks, one on the line to evict next (the victim) and one on the line that follows it (the next victim). Each line stores two flag bits for these marks. On every hit or fill the marks move, so the line just used is never the one marked for eviction.

The memory side has a single request channel. It carries line reads and word writes and is completed by an acknowledge. Each CPU request completes with a one-cycle ready pulse.

Top module: `wt4_cache`

## Requirements
- R1: After reset every line is invalid. In every set way 0 carries the victim mark and way 1 the next-victim mark. The first read to any address is a miss.
- R2: The address splits into tag bits [23:11], set index bits [10:3] and line offset [2:0]. Bit 2 selects the word within a line (0 = bytes 0..3, carried in bits 31:0 of the line). Byte enable bit k covers cpu_wdata[8k+7:8k].
- R3: A read hit raises cpu_ready in the cycle after the request is accepted, with the addressed word on cpu_rdata, and starts no memory request.
- R4: A read miss starts exactly one memory read (mem_we = 0) at the line-aligned address (bits [2:0] zero). mem_rdata carries byte offset 0 in bits 7:0. The requested word is returned with cpu_ready in the cycle mem_ack is high.
- R5: On a read miss with an invalid way in the set, the invalid way with the lowest index is filled.
- R6: On a read miss with all ways valid, the victim way is replaced. The previous next-victim becomes the victim. The new next-victim is the lowest-index way that is neither the replaced way nor the new victim.
- R7: An access to the victim way updates the marks as in R6. Here, an access means a hit of either kind or a fill. An access to the next-victim way moves that mark to the lowest-index way that is neither the victim nor the accessed way. An access to any other way leaves both marks unchanged.
- R8: Every store produces exactly one memory write. It carries the word-aligned address, cpu_wdata and cpu_be unchanged, and cpu_ready rises in the cycle mem_ack is high.
- R9: A store hit merges its enabled bytes into the cached line, so a later read hit returns the merged word. A store miss allocates nothing, so a later read of that line misses.
- R10: While mem_req is high and mem_ack is low, mem_addr and mem_we hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Request strobe, accepted while the cache is idle |
| cpu_we | input | 1 | 1 = store, 0 = read |
| cpu_addr | input | 24 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_be | input | 4 | Store byte enables |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory request active |
| mem_we | output | 1 | 1 = word write, 0 = line read |
| mem_addr | output | 24 | Line-aligned (read) or word-aligned (write) address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Write byte enables |
| mem_ack | input | 1 | Memory completion, one cycle |
| mem_rdata | input | 64 | Line data for a read, valid with mem_ack |

## Verification
A store hit changes the cached line, moves the replacement marks and starts the write-through, all from the same lookup cycle. The hazard is that one of these three effects is lost or corrupted when they coincide. The bench forces this case with directed stores to resident lines. It then rereads with partial byte enables and requires a hit with the merged word, while also checking the fields of the memory write. Random traffic confined to three sets and six tags makes store hits land on victim and next-victim ways. Its effect on later evictions is judged through the hit or miss pattern predicted by a bench model of the marks.

// File: rtl/wt4_cache_pkg.sv
package wt4_cache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOOK  = 2'd1,
    ST_FILL  = 2'd2,
    ST_WRITE = 2'd3
  } wt4_state_e;

  // index of the lowest zero bit among the first n bits of used
  function automatic int unsigned lowest_clear(input logic [31:0] used, input int unsigned n);
    int unsigned r;
    r = 0;
    for (int i = 31; i >= 0; i--) begin
      if (i < n && !used[i]) r = i;
    end
    return r;
  endfunction

  // index of the set bit of a one-hot vector
  function automatic int unsigned onehot_idx(input logic [31:0] oh);
    int unsigned r;
    r = 0;
    for (int i = 0; i < 32; i++) begin
      if (oh[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/wt4_tag_match.sv
module wt4_tag_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 13
) (
  input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [WAYS-1:0]            way_valid,
  input  logic [TAG_W-1:0]           req_tag,
  output logic [WAYS-1:0]            hit_vec,
  output logic                       hit,
  output logic [$clog2(WAYS)-1:0]    hit_way
);
  import wt4_cache_pkg::*;
  localparam int WAY_W = $clog2(WAYS);

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = way_valid[w] && (way_tag[w] == req_tag);
  end

  assign hit     = |hit_vec;
  assign hit_way = WAY_W'(onehot_idx(32'(hit_vec)));
endmodule

// File: rtl/wt4_vnv_update.sv
module wt4_vnv_update #(
  parameter int WAYS = 4
) (
  input  logic [WAYS-1:0]         vict_i,
  input  logic [WAYS-1:0]         next_i,
  input  logic [$clog2(WAYS)-1:0] way_i,
  output logic [WAYS-1:0]         vict_o,
  output logic [WAYS-1:0]         next_o
);
  import wt4_cache_pkg::*;
  logic [WAYS-1:0] acc;

  always_comb begin
    acc    = WAYS'(1) << way_i;
    vict_o = vict_i;
    next_o = next_i;
    if (acc == vict_i) begin
      vict_o = next_i;
      next_o = WAYS'(1) << lowest_clear(32'(acc | next_i), WAYS);
    end else if (acc == next_i) begin
      next_o = WAYS'(1) << lowest_clear(32'(acc | vict_i), WAYS);
    end
  end
endmodule

// File: rtl/wt4_cache.sv
module wt4_cache #(
  parameter int ADDR_W     = 24,
  parameter int SETS       = 256,
  parameter int WAYS       = 4,
  parameter int LINE_BYTES = 8,
  parameter int WORD_BYTES = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cpu_req,
  input  logic                      cpu_we,
  input  logic [ADDR_W-1:0]         cpu_addr,
  input  logic [WORD_BYTES*8-1:0]   cpu_wdata,
  input  logic [WORD_BYTES-1:0]     cpu_be,
  output logic [WORD_BYTES*8-1:0]   cpu_rdata,
  output logic                      cpu_ready,
  output logic                      mem_req,
  output logic                      mem_we,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [WORD_BYTES*8-1:0]   mem_wdata,
  output logic [WORD_BYTES-1:0]     mem_be,
  input  logic                      mem_ack,
  input  logic [LINE_BYTES*8-1:0]   mem_rdata
);
  import wt4_cache_pkg::*;

  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int BYTE_W = $clog2(WORD_BYTES);
  localparam int WSEL_W = OFF_W - BYTE_W;
  localparam int WORD_W = WORD_BYTES * 8;
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int WAY_W  = $clog2(WAYS);

  // storage
  logic [WAYS-1:0][TAG_W-1:0]  tag_q  [SETS];
  logic [WAYS-1:0][LINE_W-1:0] data_q [SETS];
  logic [WAYS-1:0]             valid_q[SETS];
  logic [WAYS-1:0]             vict_q [SETS];
  logic [WAYS-1:0]             next_q [SETS];

  // captured request
  wt4_state_e          state_q;
  logic                req_we;
  logic [ADDR_W-1:0]   req_addr;
  logic [WORD_W-1:0]   req_wdata;
  logic [WORD_BYTES-1:0] req_be;

  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  req_idx;
  logic [WSEL_W-1:0] req_wsel;
  assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
  assign req_idx  = req_addr[OFF_W +: IDX_W];
  assign req_wsel = req_addr[BYTE_W +: WSEL_W];

  // looked-up set
  logic [WAYS-1:0] lk_valid, lk_vict, lk_next, hit_vec;
  logic            ev_hit;
  logic [WAY_W-1:0] hit_way, fill_way, acc_way;
  logic [WAYS-1:0] upd_vict, upd_next;
  assign lk_valid = valid_q[req_idx];
  assign lk_vict  = vict_q[req_idx];
  assign lk_next  = next_q[req_idx];

  wt4_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .way_tag  (tag_q[req_idx]),
    .way_valid(lk_valid),
    .req_tag  (req_tag),
    .hit_vec  (hit_vec),
    .hit      (ev_hit),
    .hit_way  (hit_way)
  );

  assign fill_way = (&lk_valid) ? WAY_W'(onehot_idx(32'(lk_vict)))
                                : WAY_W'(lowest_clear(32'(lk_valid), WAYS));
  assign acc_way  = (state_q == ST_FILL) ? fill_way : hit_way;

  wt4_vnv_update #(.WAYS(WAYS)) u_vnv (
    .vict_i(lk_vict),
    .next_i(lk_next),
    .way_i (acc_way),
    .vict_o(upd_vict),
    .next_o(upd_next)
  );

  // named events for the checker
  logic ev_lookup, ev_fill_done, ev_store_hit;
  assign ev_lookup    = (state_q == ST_LOOK);
  assign ev_fill_done = (state_q == ST_FILL) && mem_ack;
  assign ev_store_hit = ev_lookup && req_we && ev_hit;

  function automatic logic [WORD_W-1:0] word_of(input logic [LINE_W-1:0] line,
                                                input logic [WSEL_W-1:0] sel);
    return line[sel*WORD_W +: WORD_W];
  endfunction

  function automatic logic [LINE_W-1:0] merge_line(input logic [LINE_W-1:0] line,
                                                   input logic [WSEL_W-1:0] sel,
                                                   input logic [WORD_W-1:0] wd,
                                                   input logic [WORD_BYTES-1:0] be);
    logic [LINE_W-1:0] r;
    r = line;
    for (int b = 0; b < WORD_BYTES; b++) begin
      if (be[b]) r[sel*WORD_W + b*8 +: 8] = wd[b*8 +: 8];
    end
    return r;
  endfunction

  // control and replacement state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      req_we    <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
      req_be    <= '0;
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        vict_q[s]  <= WAYS'(1);
        next_q[s]  <= WAYS'(2);
      end
    end else begin
      unique case (state_q)
        ST_IDLE: if (cpu_req) begin
          req_we    <= cpu_we;
          req_addr  <= cpu_addr;
          req_wdata <= cpu_wdata;
          req_be    <= cpu_be;
          state_q   <= ST_LOOK;
        end
        ST_LOOK: begin
          if (ev_hit) begin
            vict_q[req_idx] <= upd_vict;
            next_q[req_idx] <= upd_next;
          end
          if (req_we)      state_q <= ST_WRITE;
          else if (ev_hit) state_q <= ST_IDLE;
          else             state_q <= ST_FILL;
        end
        ST_FILL: if (mem_ack) begin
          valid_q[req_idx][fill_way] <= 1'b1;
          vict_q[req_idx]            <= upd_vict;
          next_q[req_idx]            <= upd_next;
          state_q                    <= ST_IDLE;
        end
        ST_WRITE: if (mem_ack) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // line and tag storage, no reset
  always_ff @(posedge clk) begin
    if (ev_store_hit)
      data_q[req_idx][hit_way] <= merge_line(data_q[req_idx][hit_way], req_wsel, req_wdata, req_be);
    if (ev_fill_done) begin
      data_q[req_idx][fill_way] <= mem_rdata;
      tag_q[req_idx][fill_way]  <= req_tag;
    end
  end

  // outputs
  assign cpu_ready = (ev_lookup && !req_we && ev_hit) || ev_fill_done ||
                     ((state_q == ST_WRITE) && mem_ack);
  assign cpu_rdata = (state_q == ST_FILL) ? word_of(mem_rdata, req_wsel)
                                          : word_of(data_q[req_idx][hit_way], req_wsel);
  assign mem_req   = (state_q == ST_FILL) || (state_q == ST_WRITE);
  assign mem_we    = (state_q == ST_WRITE);
  assign mem_addr  = mem_we ? {req_addr[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}}
                            : {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign mem_wdata = req_wdata;
  assign mem_be    = req_be;
endmodule

// File: rtl/wt4_cache_chk.sv
module wt4_cache_chk #(
  parameter int ADDR_W     = 24,
  parameter int WAYS       = 4,
  parameter int LINE_BYTES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_lookup,
  input logic              ev_hit,
  input logic              req_we,
  input logic [WAYS-1:0]   hit_vec,
  input logic [WAYS-1:0]   lk_vict,
  input logic [WAYS-1:0]   lk_next,
  input logic              cpu_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  p_single_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lookup |-> $onehot0(hit_vec));

  p_read_hit_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_lookup && !req_we && ev_hit) |-> (cpu_ready && !mem_req));

  p_marks_distinct_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lookup |-> ($onehot(lk_vict) && $onehot(lk_next) && ((lk_vict & lk_next) == '0)));

  p_miss_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_lookup && !req_we && !ev_hit) |=> (mem_req && !mem_we));

  p_fill_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (mem_addr[OFF_W-1:0] == '0));

  p_store_forward_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_lookup && req_we) |=> (mem_req && mem_we));

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  p_ready_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);
endmodule

bind wt4_cache wt4_cache_chk #(.ADDR_W(ADDR_W), .WAYS(WAYS), .LINE_BYTES(LINE_BYTES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ev_lookup(ev_lookup),
  .ev_hit   (ev_hit),
  .req_we   (req_we),
  .hit_vec  (hit_vec),
  .lk_vict  (lk_vict),
  .lk_next  (lk_next),
  .cpu_ready(cpu_ready),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_ack  (mem_ack),
  .mem_addr (mem_addr)
);

// File: tb/wt4_cache_bench.sv
module wt4_cache_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [23:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [3:0]  cpu_be = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_ready;
  logic        mem_req, mem_we;
  logic [23:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [3:0]  mem_be;
  logic        mem_ack = 1'b0;
  logic [63:0] mem_rdata = '0;

  always #10 clk = ~clk;  // 50 MHz

  wt4_cache u_wt4_cache (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_be(cpu_be), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int tests = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ---------------- memory environment ----------------
  logic [31:0] bmem [int];
  function automatic logic [31:0] word_at(input int wa);
    if (bmem.exists(wa)) return bmem[wa];
    return (wa * 32'h9E3779B1) ^ 32'hC3A50F0F;
  endfunction

  int          rd_count = 0, wr_count = 0, mem_wait = 0;
  logic [23:0] rd_addr, wr_addr;
  logic [31:0] wr_data;
  logic [3:0]  wr_be;

  initial begin
    forever begin
      @(posedge clk); #2;
      if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (mem_req) begin
        if (mem_wait == 2) begin
          mem_wait = 0;
          if (mem_we) begin
            logic [31:0] w;
            wr_count++;
            wr_addr = mem_addr; wr_data = mem_wdata; wr_be = mem_be;
            w = word_at(int'(mem_addr >> 2));
            for (int b = 0; b < 4; b++) if (mem_be[b]) w[b*8 +: 8] = mem_wdata[b*8 +: 8];
            bmem[int'(mem_addr >> 2)] = w;
          end else begin
            rd_count++;
            rd_addr = mem_addr;
            mem_rdata = {word_at(int'(mem_addr >> 2) + 1), word_at(int'(mem_addr >> 2))};
          end
          mem_ack = 1'b1;
        end else begin
          mem_wait++;
        end
      end
    end
  end

  // ---------------- reference model of tags and marks ----------------
  bit          m_valid [256][4];
  logic [12:0] m_tag   [256][4];
  int          m_vict  [256];
  int          m_next  [256];

  function automatic int free_way(input int s, input int a, input int b);
    for (int k = 0; k < 4; k++) if (k != a && k != b) return k;
    return 0;
  endfunction

  function automatic void touch(input int s, input int w);
    if (w == m_vict[s]) begin
      m_vict[s] = m_next[s];
      m_next[s] = free_way(s, w, m_vict[s]);
    end else if (w == m_next[s]) begin
      m_next[s] = free_way(s, w, m_vict[s]);
    end
  endfunction

  function automatic int find_way(input int s, input logic [12:0] t);
    for (int k = 0; k < 4; k++) if (m_valid[s][k] && m_tag[s][k] == t) return k;
    return -1;
  endfunction

  function automatic int pick_fill(input int s);
    for (int k = 0; k < 4; k++) if (!m_valid[s][k]) return k;
    return m_vict[s];
  endfunction

  // ---------------- one CPU access ----------------
  task automatic access(input bit we, input logic [23:0] a, input logic [31:0] wd,
                        input logic [3:0] be, input string req, output bit was_hit);
    int s, w, rd0, wr0, cyc;
    logic [12:0] t;
    logic [31:0] got;
    s = int'(a[10:3]); t = a[23:11];
    w = find_way(s, t);
    was_hit = (w >= 0);
    rd0 = rd_count; wr0 = wr_count;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_be = be;
    @(posedge clk); #1;
    cpu_req = 1'b0;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!cpu_ready && cyc < 200);
    got = cpu_rdata;
    chk(cpu_ready, req, "completion", 32'(cpu_ready), 32'd1);
    if (!we) begin
      chk(got == word_at(int'(a >> 2)), req, "read data", got, word_at(int'(a >> 2)));
      chk((rd_count - rd0) == (was_hit ? 0 : 1), req, was_hit ? "hit expected" : "miss expected",
          32'(rd_count - rd0), was_hit ? 32'd0 : 32'd1);
      if (was_hit) chk(cyc == 1, req, "hit latency R3", 32'(cyc), 32'd1);
      else begin
        chk(rd_addr == {a[23:3], 3'b000}, req, "fill address R4", 32'(rd_addr), 32'({a[23:3], 3'b000}));
        w = pick_fill(s);
        m_valid[s][w] = 1'b1;
        m_tag[s][w] = t;
      end
      touch(s, w);
    end else begin
      chk((wr_count - wr0) == 1 && rd_count == rd0, req, "one write, no read R8",
          32'(wr_count - wr0), 32'd1);
      chk(wr_addr == {a[23:2], 2'b00}, req, "write address R8", 32'(wr_addr), 32'({a[23:2], 2'b00}));
      chk(wr_data == wd, req, "write data R8", wr_data, wd);
      chk(wr_be == be, req, "write enables R8", 32'(wr_be), 32'(be));
      if (was_hit) touch(s, w);
    end
    @(posedge clk); #1;
    chk(!cpu_ready, req, "ready is one pulse", 32'(cpu_ready), 32'd0);
  endtask

  function automatic logic [23:0] mk(input int t, input int s, input int off);
    return {13'(t), 8'(s), 3'(off)};
  endfunction

  // ---------------- stimulus ----------------
  bit h;
  initial begin
    for (int s = 0; s < 256; s++) begin
      m_vict[s] = 0; m_next[s] = 1;
      for (int k = 0; k < 4; k++) m_valid[s][k] = 1'b0;
    end
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!cpu_ready && !mem_req, "R1", "idle after reset", 32'({cpu_ready, mem_req}), 32'd0);

    // R1/R4: cold read misses, word select R2
    access(1'b0, mk(1, 3, 4), '0, '0, "R1", h);
    chk(!h, "R1", "first read misses", 32'(h), 32'd0);
    access(1'b0, mk(1, 3, 0), '0, '0, "R2", h);
    chk(h, "R3", "reread of line hits", 32'(h), 32'd1);
    // R5: lowest invalid ways fill, then R6 evictions in set 3
    access(1'b0, mk(2, 3, 0), '0, '0, "R5", h);
    access(1'b0, mk(3, 3, 0), '0, '0, "R5", h);
    access(1'b0, mk(4, 3, 4), '0, '0, "R5", h);
    access(1'b0, mk(5, 3, 0), '0, '0, "R6", h);   // evicts way 0 (tag 1)
    access(1'b0, mk(1, 3, 0), '0, '0, "R6", h);
    chk(!h, "R6", "evicted victim line misses", 32'(h), 32'd0);
    access(1'b0, mk(4, 3, 0), '0, '0, "R7", h);   // non-marked way hit
    chk(h, "R7", "unmarked way still resident", 32'(h), 32'd1);
    access(1'b0, mk(3, 3, 0), '0, '0, "R7", h);
    access(1'b0, mk(6, 3, 0), '0, '0, "R6", h);
    access(1'b0, mk(4, 3, 0), '0, '0, "R7", h);

    // R9: store hit merges, store miss does not allocate
    access(1'b0, mk(7, 9, 0), '0, '0, "R4", h);
    access(1'b1, mk(7, 9, 4), 32'hA1B2C3D4, 4'b0101, "R9", h);
    chk(h, "R9", "store hit", 32'(h), 32'd1);
    access(1'b0, mk(7, 9, 4), '0, '0, "R9", h);
    chk(h, "R9", "merged word read hit", 32'(h), 32'd1);
    access(1'b1, mk(8, 9, 0), 32'h0BADF00D, 4'b1111, "R9", h);
    access(1'b0, mk(8, 9, 0), '0, '0, "R9", h);
    chk(!h, "R9", "store miss left no line", 32'(h), 32'd0);

    // constrained random on three sets, six tags
    for (int n = 0; n < 600; n++) begin
      int sets3[3] = '{5, 77, 200};
      bit we;
      logic [3:0] be;
      we = ($urandom % 10) < 3;
      be = 4'($urandom % 15 + 1);
      access(we, mk(int'($urandom % 6), sets3[$urandom % 3], int'($urandom % 2) * 4),
             $urandom, be, we ? "R8" : "R7", h);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule